// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller

This block collects up to 32 peripheral interrupt sources and presents a single request line to a processor core. Each source has a pending bit, set by its event input, and an enable bit in a mask register. The core reads and writes four registers through a simple register port. When the core writes the acknowledge bit of the vector register, the block picks the highest-priority eligible source and publishes its 5-bit vector. In the same clock edge it marks that source in service and drops its pending bit.

In-service bits are cleared only by software, which writes ones to them. A source is eligible only if it outranks every source already in service. This lets a more urgent handler preempt a less urgent one, and several in-service bits can be set at once. An acknowledge that finds no eligible source returns the error vector 0 and changes no other state. This covers the case where software masks a request after it was raised but before it was acknowledged. Some bit positions are reserved: they never hold state and always read zero.

Top module: `vic_nest_ctrl`

## Requirements
- R1: After reset the pending, mask and in-service registers and the vector field are all zero, and `irq_req` is low.
- R2: A source whose `src_evt` bit is high at a clock edge has its pending bit set at that edge. If the same source is acknowledged at that edge, the event wins and the pending bit stays set. Register address 0 returns the pending bits and ignores writes.
- R3: Register address 1 is the mask register. It is read/write, and a 1 enables the source with the same bit index.
- R4: Bit index 0 has the highest priority. A source is eligible when it is pending, enabled, and has a lower index than the lowest-index in-service bit (any index when nothing is in service). `irq_req` is high exactly when at least one source is eligible.
- R5: A write to address 3 with data bit 0 set is an acknowledge. At that clock edge the lowest-index eligible source i gets its in-service bit set and its pending bit cleared, and the vector field becomes 31 − i. Address 3 reads the vector field in bits [5:1], with bit 0 reading 0.
- R6: Address 2 is the in-service register. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and no write can set a bit.
- R7: Nested servicing is possible: an eligible higher-priority source may be acknowledged while lower-priority sources are in service, leaving several in-service bits set.
- R8: An acknowledge with no eligible source writes the error vector 0 and leaves the pending and in-service registers unchanged. This holds whatever the mask holds, including a source that was masked after it raised `irq_req`.
- R9: Reserved positions (indices 3, 18, 22 and 31 by default) read 0 in the pending, mask and in-service registers and ignore events and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 32 | Per-source event inputs; a high bit sets that source's pending bit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pending, 1 mask, 2 in-service, 3 vector |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Interrupt request toward the core |

## Verification
The hardest state to reach from the ports is a request that was raised and then masked before the acknowledge, while other sources are blocked by in-service bits or are not pending. The error vector must come out only then, and no source's bookkeeping may change. Directed sequences build this state: they raise a request, check that `irq_req` is high, clear the mask, and acknowledge. A nesting sequence acknowledges bit 12, then raises and acknowledges bit 5, and also shows that a lower-priority source stays blocked. Random stimulus with a fixed seed mixes sparse events, mask writes, acknowledges and partial write-one-to-clear patterns, so that the blocking threshold moves up and down many times.

// File: rtl/vic_pkg.sv
// Package: shared register map and constants for the nested vectored
// interrupt controller. Assumes a 2-bit register address space.
package vic_pkg;
    typedef enum logic [1:0] {
        ADDR_PEND = 2'd0,
        ADDR_MASK = 2'd1,
        ADDR_INSV = 2'd2,
        ADDR_VECT = 2'd3
    } vic_addr_e;

    localparam int ACK_BIT = 0;
    localparam int DATA_W  = 32;
endpackage

// File: rtl/vic_prio_pick.sv
// Module: fixed-priority picker. Returns the lowest set index of req.
// Assumes index 0 is the most urgent; idx is 0 when vld is low.
module vic_prio_pick #(
    parameter int N     = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             vld,
    output logic [IDX_W-1:0] idx
);
    // Scan from the least urgent end so the most urgent hit is kept last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        vld = |req;
    end
endmodule

// File: rtl/vic_src_bank.sv
// Module: per-source pending and in-service storage. Builds one slice per
// source; reserved positions are built as constant zero.
// Assumes claim_vld pulses for one cycle per acknowledge.
module vic_src_bank #(
    parameter int          N         = 32,
    parameter logic [N-1:0] RSVD_MASK = '0,
    localparam int         IDX_W     = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     evt,
    input  logic             claim_vld,
    input  logic [IDX_W-1:0] claim_idx,
    input  logic             clr_we,
    input  logic [N-1:0]     clr_bits,
    output logic [N-1:0]     pend,
    output logic [N-1:0]     insv
);
    for (genvar i = 0; i < N; i++) begin : g_src
        if (RSVD_MASK[i]) begin : g_rsvd
            assign pend[i] = 1'b0;
            assign insv[i] = 1'b0;
        end else begin : g_live
            logic hit;
            assign hit = claim_vld && (claim_idx == IDX_W'(i));

            // Pending: events set it (and win over a same-edge claim).
            always_ff @(posedge clk) begin
                if (!rst_n)      pend[i] <= 1'b0;
                else if (evt[i]) pend[i] <= 1'b1;
                else if (hit)    pend[i] <= 1'b0;
            end

            // In-service: set by a claim, cleared by a write of one.
            always_ff @(posedge clk) begin
                if (!rst_n)                    insv[i] <= 1'b0;
                else if (hit)                  insv[i] <= 1'b1;
                else if (clr_we && clr_bits[i]) insv[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vic_nest_ctrl.sv
// Module: top of the nested vectored interrupt controller. Decodes the
// register port, holds the mask and vector, gates eligibility by the
// in-service threshold and drives the request line.
// Assumes N_SRC <= 32 and that reserved positions include the index whose
// vector would be 0, so that vector 0 means only the error case.
module vic_nest_ctrl
    import vic_pkg::*;
#(
    parameter int               N_SRC     = 32,
    parameter logic [N_SRC-1:0] RSVD_MASK = 32'h8044_0008,
    localparam int              IDX_W     = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_evt,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req
);
    logic [N_SRC-1:0] pend_q, isr_q, mask_q;
    logic [N_SRC-1:0] isr_lo, allow, elig;
    logic [IDX_W-1:0] vec_q, pick_idx;
    logic             pick_vld, ack, isr_wr;

    // Register-port decode of the acknowledge and in-service clear.
    always_comb begin
        ack    = reg_we && (reg_addr == ADDR_VECT) && reg_wdata[ACK_BIT];
        isr_wr = reg_we && (reg_addr == ADDR_INSV);
    end

    // Threshold: only indices below the lowest in-service bit may compete.
    always_comb begin
        isr_lo = isr_q & (~isr_q + N_SRC'(1));
        allow  = isr_lo - N_SRC'(1);
        elig   = pend_q & mask_q & allow;
    end

    vic_prio_pick #(.N(N_SRC)) u_pick (
        .req (elig),
        .vld (pick_vld),
        .idx (pick_idx)
    );

    vic_src_bank #(.N(N_SRC), .RSVD_MASK(RSVD_MASK)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (src_evt),
        .claim_vld (ack && pick_vld),
        .claim_idx (pick_idx),
        .clr_we    (isr_wr),
        .clr_bits  (reg_wdata[N_SRC-1:0]),
        .pend      (pend_q),
        .insv      (isr_q)
    );

    // Mask register: software enables, reserved positions held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                               mask_q <= '0;
        else if (reg_we && reg_addr == ADDR_MASK) mask_q <= reg_wdata[N_SRC-1:0] & ~RSVD_MASK;
    end

    // Vector field: source vector on a successful claim, error vector else.
    always_ff @(posedge clk) begin
        if (!rst_n)        vec_q <= '0;
        else if (ack)      vec_q <= pick_vld ? (IDX_W'(N_SRC - 1) - pick_idx) : '0;
    end

    // Request line: any eligible source.
    assign irq_req = pick_vld;

    // Read mux for the register port.
    always_comb begin
        unique case (reg_addr)
            ADDR_PEND: reg_rdata = DATA_W'(pend_q);
            ADDR_MASK: reg_rdata = DATA_W'(mask_q);
            ADDR_INSV: reg_rdata = DATA_W'(isr_q);
            default:   reg_rdata = DATA_W'({vec_q, 1'b0});
        endcase
    end
endmodule

// File: rtl/vic_nest_chk.sv
// Module: assertion checker for vic_nest_ctrl, attached with bind.
// Assumes reset is held for at least one clock before release.
module vic_nest_chk #(
    parameter int               N_SRC     = 32,
    parameter logic [N_SRC-1:0] RSVD_MASK = '0,
    localparam int              IDX_W     = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [N_SRC-1:0] pend_q,
    input logic [N_SRC-1:0] isr_q,
    input logic [N_SRC-1:0] mask_q,
    input logic [IDX_W-1:0] vec_q,
    input logic             irq_req
);
    logic ack_w, clr_w;
    assign ack_w = reg_we && reg_addr == 2'd3 && reg_wdata[0];
    assign clr_w = reg_we && reg_addr == 2'd2;

    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q | isr_q | mask_q) & RSVD_MASK) == '0);

    assert_isr_set_by_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_w |=> $countones(isr_q & ~$past(isr_q)) == 0);

    assert_isr_one_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_w |=> $countones(isr_q & ~$past(isr_q)) <= 1);

    assert_isr_clear_by_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_w |=> ($past(isr_q) & ~isr_q) == '0);

    assert_req_needs_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_q & mask_q) != '0);

    assert_error_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_w && !irq_req) |=> vec_q == '0 && $stable(isr_q));

    assert_claim_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_w && irq_req) |=> vec_q != '0);
endmodule

bind vic_nest_ctrl vic_nest_chk #(.N_SRC(N_SRC), .RSVD_MASK(RSVD_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pend_q    (pend_q),
    .isr_q     (isr_q),
    .mask_q    (mask_q),
    .vec_q     (vec_q),
    .irq_req   (irq_req)
);

// File: tb/vic_nest_ctrl_test.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a behavioural model built from the requirements.
module vic_nest_ctrl_test;
    localparam logic [31:0] RSVD = 32'h8044_0008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_evt = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_pend = '0, m_mask = '0, m_isr = '0;
    logic [4:0]  m_vec = '0;

    always #10 clk = ~clk;   // 50 MHz

    vic_nest_ctrl uut (.*);

    function automatic logic [31:0] elig_of(logic [31:0] p, logic [31:0] m, logic [31:0] s);
        logic [31:0] thr = '1;
        for (int i = 31; i >= 0; i--) if (s[i]) thr = (32'd1 << i) - 32'd1;
        return p & m & thr;
    endfunction

    function automatic logic [31:0] rd_exp(logic [1:0] a);
        case (a)
            2'd0: return m_pend;
            2'd1: return m_mask;
            2'd2: return m_isr;
            default: return {26'd0, m_vec, 1'b0};
        endcase
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One clock of stimulus; the model advances with the design.
    task automatic step(logic we, logic [1:0] a, logic [31:0] d, logic [31:0] ev);
        logic [31:0] e;
        int idx;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; src_evt = ev;
        e = elig_of(m_pend, m_mask, m_isr);
        @(posedge clk);
        #2;
        if (we && a == 2'd3 && d[0]) begin
            if (e != 0) begin
                idx = 0;
                for (int i = 31; i >= 0; i--) if (e[i]) idx = i;
                m_vec = 5'(31 - idx);
                m_isr[idx] = 1'b1;
                m_pend[idx] = 1'b0;
            end else m_vec = '0;
        end
        if (we && a == 2'd1) m_mask = d & ~RSVD;
        if (we && a == 2'd2) m_isr = m_isr & ~d;
        m_pend = m_pend | (ev & ~RSVD);
        check("R4 irq_req", 32'(irq_req), 32'(elig_of(m_pend, m_mask, m_isr) != 0));
        reg_we = 1'b0; src_evt = '0;
    endtask

    task automatic rd(string req, logic [1:0] a);
        @(negedge clk);
        reg_we = 1'b0; src_evt = '0; reg_addr = a;
        #2 check(req, reg_rdata, rd_exp(a));
    endtask

    task automatic rd_all(string req);
        for (int a = 0; a < 4; a++) rd(req, 2'(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4177));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        rd_all("R1 reset");
        check("R1 irq low", 32'(irq_req), 32'd0);

        // R3 / R9: mask write with all ones, reserved stay zero
        step(1, 2'd1, 32'hFFFF_FFFF, '0);
        rd("R3 mask rw", 2'd1);
        check("R9 reserved mask", reg_rdata & RSVD, 32'd0);
        // R9: events on reserved positions ignored; R2 pending read-only
        step(0, 2'd0, RSVD, RSVD);
        step(1, 2'd0, 32'hFFFF_FFFF, '0);
        rd("R9 reserved pend", 2'd0);
        check("R2 pend ro", reg_rdata, 32'd0);

        // R7 nesting: bit 12 then bit 5 preempts; bit 20 blocked
        step(0, 2'd0, 0, 32'h0000_1000);
        step(1, 2'd3, 32'd1, '0);
        rd("R5 vec 19", 2'd3);
        check("R5 vector value", reg_rdata, {26'd0, 5'd19, 1'b0});
        step(0, 2'd0, 0, 32'h0010_0000);
        check("R4 blocked low prio", 32'(irq_req), 32'd0);
        step(0, 2'd0, 0, 32'h0000_0020);
        check("R7 preempt req", 32'(irq_req), 32'd1);
        step(1, 2'd3, 32'd1, '0);
        rd("R7 isr", 2'd2);
        check("R7 two in service", reg_rdata, 32'h0000_1020);
        rd("R7 vec 26", 2'd3);
        // R6: zero write no effect, then clear bit 5 only
        step(1, 2'd2, 32'h0000_0000, '0);
        rd("R6 zeros ignored", 2'd2);
        step(1, 2'd2, 32'h0000_0020, '0);
        rd("R6 w1c", 2'd2);
        step(1, 2'd2, 32'h0000_1000, '0);
        check("R4 unblocked", 32'(irq_req), 32'd1);
        // R2: event same edge as its own ack keeps pending
        step(1, 2'd3, 32'd1, 32'h0010_0000);
        rd("R2 event wins", 2'd0);
        step(1, 2'd2, 32'hFFFF_FFFF, '0);

        // R8: raise bit 7, mask it, acknowledge -> error vector 0
        step(1, 2'd1, 32'h0000_0080, 32'h0000_0080);
        check("R8 raised", 32'(irq_req), 32'd1);
        step(1, 2'd1, 32'h0000_0000, '0);
        step(1, 2'd3, 32'd1, '0);
        rd("R8 error vec", 2'd3);
        check("R8 vector zero", reg_rdata, 32'd0);
        rd("R8 isr untouched", 2'd2);
        rd("R8 pend kept", 2'd0);

        // Random traffic
        for (int k = 0; k < 4000; k++) begin
            int op = $urandom_range(0, 99);
            if (op < 35)      step(0, 2'd0, 0, $urandom & $urandom & $urandom);
            else if (op < 48) step(1, 2'd1, $urandom | $urandom, '0);
            else if (op < 66) step(1, 2'd3, {$urandom, 1'b1}, '0);
            else if (op < 80) step(1, 2'd2, $urandom & $urandom, '0);
            else if (op < 84) step(1, 2'd0, $urandom, '0);
            else              rd("R5 random read", 2'($urandom_range(0, 3)));
        end
        rd_all("R4 final");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule